// File: doc/BRIEF.md
# Segmented Bus Symbol Broadcaster

This block models a linear chain of processing nodes joined by a reconfigurable bus. Between its two bus ports, each node has a local switch. When every switch is closed, the chain forms one continuous bus. A node that holds the symbol being sent in the current time slot opens its switch. It then drives the symbol number onto the stretch of bus between itself and the receiver. The receiver sits past the last node and sees only the segment that begins at the nearest open switch. A node that is not driving contributes nothing, so the receiver reads zero when no node drives its segment.

A single start pulse runs one broadcast round. The round steps through symbols 1 to K, one symbol per clock slot. In each slot the receiver records whether that symbol arrived. When the last slot ends, the block raises done for one cycle. At that point the K-bit presence vector says which symbols some node holds. The vector stays stable until the next round starts.

The block has no streaming data path. Its inputs are a static mask of held symbols, which must stay stable while a round runs, and a start strobe. Its outputs are plain status and result signals, so there is no valid/ready back-pressure.

Top module: `seg_bus_bcast`

## Requirements
- R1: After reset, busy, done and the slot number are 0, the presence vector is all zeros and the receiver reads value 0.
- R2: A start pulse while the block is idle makes the slot number 1 in the next cycle. The slot number then rises by one each cycle up to K, and busy is high exactly while the slot number is nonzero.
- R3: The cycle after slot K, the slot number returns to 0 and done is high for exactly that one cycle.
- R4: When done is high, presence bit s-1 is 1 exactly when at least one node holds symbol s. Node i holds symbol s when hold bit i*K + s-1 is 1.
- R5: During slot s, the receiver value equals s if any node holds symbol s, and is 0 otherwise (undriven bus reads as zero).
- R6: During slot s, rx_node gives the highest-numbered node holding symbol s, because node NODES-1 is nearest the receiver. It is 0 when no node drives.
- R7: A start pulse while busy is ignored: the slot sequence and the done timing continue unchanged.
- R8: Accepting a start clears the presence vector. After done, the vector holds its value until the next accepted start.
- R9: While idle, the receiver value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a broadcast round when idle |
| hold | input | NODES*SYMS | Symbol mask per node; node i owns bits [i*SYMS +: SYMS] |
| busy | output | 1 | A round is in progress |
| slot | output | $clog2(SYMS+1) | Current symbol number, 0 when idle |
| rx_val | output | $clog2(SYMS+1) | Value seen by the receiver on its segment |
| rx_node | output | $clog2(NODES) | Index of the node driving the receiver's segment |
| done | output | 1 | One-cycle pulse at the end of a round |
| presence | output | SYMS | Per-symbol presence vector |

## Verification
The assertions check the following on every cycle:
- slot stepping;
- the one-cycle done pulse;
- that a start pulse arriving while busy cannot restart the round;
- that the receiver value is either zero or the current slot number;
- that the bus is quiet while idle.

Only the bench's scenarios can show the following:
- which node is nearest when several nodes hold the same symbol;
- that the presence vector matches the OR of the hold masks over several patterns;
- that the vector is cleared at start and held after done.

// File: rtl/seg_bus_pkg.sv
package seg_bus_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/seg_bus_sequencer.sv
module seg_bus_sequencer
  import seg_bus_pkg::*;
#(
  parameter int SYMS = 4,
  localparam int SW = $clog2(SYMS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          go,
  output logic [SW-1:0] slot,
  output logic          busy,
  output logic          done
);
  localparam logic [SW-1:0] LAST = SW'(SYMS);

  seq_state_e state;

  assign go   = start && (state == SEQ_IDLE);
  assign busy = (state == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      slot  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        state <= SEQ_RUN;
        slot  <= SW'(1);
      end else if (state == SEQ_RUN) begin
        if (slot == LAST) begin
          state <= SEQ_IDLE;
          slot  <= '0;
          done  <= 1'b1;
        end else begin
          slot <= slot + SW'(1);
        end
      end
    end
  end

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != LAST) |=> (slot == $past(slot) + SW'(1)));
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (slot == '0));
  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (slot != SW'(1)));
endmodule

// File: rtl/seg_bus_node.sv
module seg_bus_node #(
  parameter int SYMS  = 4,
  parameter int NODES = 8,
  parameter int IDX   = 0,
  localparam int SW = $clog2(SYMS + 1),
  localparam int IW = $clog2(NODES)
) (
  input  logic [SYMS-1:0] held,
  input  logic [SW-1:0]   slot,
  input  logic [SW-1:0]   up_val,
  input  logic [IW-1:0]   up_src,
  output logic [SW-1:0]   dn_val,
  output logic [IW-1:0]   dn_src
);
  logic drive;

  always_comb begin
    drive = 1'b0;
    for (int s = 0; s < SYMS; s++) begin
      if (slot == SW'(s + 1) && held[s]) drive = 1'b1;
    end
  end

  // an open switch cuts the upstream segment; this node drives the new one
  assign dn_val = drive ? slot : up_val;
  assign dn_src = drive ? IW'(IDX) : up_src;
endmodule

// File: rtl/seg_bus_collector.sv
module seg_bus_collector #(
  parameter int SYMS = 4,
  localparam int SW = $clog2(SYMS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [SW-1:0]   slot,
  input  logic [SW-1:0]   rx_val,
  output logic [SYMS-1:0] presence
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presence <= '0;
    end else if (go) begin
      presence <= '0;
    end else begin
      for (int s = 0; s < SYMS; s++) begin
        if (slot == SW'(s + 1)) presence[s] <= (rx_val != '0);
      end
    end
  end

  // R5
  rx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_val != '0) |-> (rx_val == slot));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == '0) |-> (rx_val == '0));
endmodule

// File: rtl/seg_bus_bcast.sv
module seg_bus_bcast #(
  parameter int NODES = 8,
  parameter int SYMS  = 4,
  localparam int SW = $clog2(SYMS + 1),
  localparam int IW = $clog2(NODES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NODES*SYMS-1:0] hold,
  output logic                  busy,
  output logic [SW-1:0]         slot,
  output logic [SW-1:0]         rx_val,
  output logic [IW-1:0]         rx_node,
  output logic                  done,
  output logic [SYMS-1:0]       presence
);
  logic go;
  logic [SW-1:0] seg_val [NODES+1];
  logic [IW-1:0] seg_src [NODES+1];

  seg_bus_sequencer #(.SYMS(SYMS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .go(go), .slot(slot), .busy(busy), .done(done)
  );

  // far end of the chain floats: modelled as zero
  assign seg_val[0] = '0;
  assign seg_src[0] = '0;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    seg_bus_node #(.SYMS(SYMS), .NODES(NODES), .IDX(i)) u_node (
      .held  (hold[i*SYMS +: SYMS]),
      .slot  (slot),
      .up_val(seg_val[i]),
      .up_src(seg_src[i]),
      .dn_val(seg_val[i+1]),
      .dn_src(seg_src[i+1])
    );
  end

  assign rx_val  = seg_val[NODES];
  assign rx_node = seg_src[NODES];

  seg_bus_collector #(.SYMS(SYMS)) u_rx (
    .clk(clk), .rst_n(rst_n), .go(go), .slot(slot),
    .rx_val(rx_val), .presence(presence)
  );

  // R2
  busy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (slot != '0));
endmodule

// File: tb/seg_bus_bcast_test.sv
`timescale 1ns/1ps
module seg_bus_bcast_test;
  localparam int NODES = 8;
  localparam int SYMS  = 4;
  localparam int SW = $clog2(SYMS + 1);
  localparam int IW = $clog2(NODES);

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [NODES*SYMS-1:0] hold = '0;
  logic busy, done;
  logic [SW-1:0] slot, rx_val;
  logic [IW-1:0] rx_node;
  logic [SYMS-1:0] presence;

  int checks = 0;
  int errors = 0;

  seg_bus_bcast #(.NODES(NODES), .SYMS(SYMS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .hold(hold),
    .busy(busy), .slot(slot), .rx_val(rx_val), .rx_node(rx_node),
    .done(done), .presence(presence)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_val(input int s);
    for (int i = 0; i < NODES; i++)
      if (hold[i*SYMS + s - 1]) return s;
    return 0;
  endfunction

  function automatic int exp_node(input int s);
    int n = 0;
    for (int i = 0; i < NODES; i++)
      if (hold[i*SYMS + s - 1]) n = i;
    return n;
  endfunction

  function automatic int exp_pres();
    int p = 0;
    for (int s = 1; s <= SYMS; s++)
      if (exp_val(s) != 0) p |= (1 << (s - 1));
    return p;
  endfunction

  task automatic test_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 slot", slot, 0);
    chk("R1 presence", presence, 0);
    chk("R1 rx_val", rx_val, 0);
  endtask

  // runs one round; poke_at>0 pulses start during that slot
  task automatic run_round(input logic [NODES*SYMS-1:0] pat, input int poke_at);
    int ep;
    hold = pat;
    ep = exp_pres();
    @(negedge clk);
    chk("R9 idle rx_val", rx_val, 0);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R8 cleared", presence, 0);
    for (int s = 1; s <= SYMS; s++) begin
      chk("R2 slot", slot, s);
      chk("R2 busy", busy, 1);
      chk("R3 no early done", done, 0);
      chk("R5 rx_val", rx_val, exp_val(s));
      chk("R6 rx_node", rx_node, exp_node(s));
      if (s == poke_at) start = 1;
      @(negedge clk);
      start = 0;
    end
    chk("R3 done", done, 1);
    chk("R3 slot zero", slot, 0);
    chk("R7 busy low", busy, 0);
    chk("R4 presence", presence, ep);
    @(negedge clk);
    chk("R3 done pulse", done, 0);
    chk("R8 held", presence, ep);
    chk("R9 idle rx_val", rx_val, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    run_round('0, 0);                                  // nothing held
    run_round(32'h0000_2000, 0);                        // node 3 holds symbol 2
    run_round(32'h0010_0010, 0);                        // nodes 1 and 5 hold symbol 1
    run_round(32'hFFFF_FFFF, 0);                        // every node holds every symbol
    run_round(32'h0000_0008, 0);                        // node 0 only, symbol 4
    run_round(32'h1020_4080, 2);                        // R7 start poked while busy
    run_round(32'h8421_0000, 0);                        // upper nodes, mixed symbols
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule